// File: doc/BRIEF.md
# Address Space Tagged Translation Buffer with Software Refill

This block is a small fully associative translation cache. A lookup presents a virtual address and the identifier of the running address space. One cycle later the block reports either a hit with the physical address, or a miss. Software treats a miss as a trap. The page is 16 bytes, so the low four address bits are the page offset and are carried through unchanged. The upper bits form the virtual page number, which maps to a physical frame number.

There is no hardware page walker. After a miss, a trap handler reads the page table and installs the translation through a write port. That port only accepts a write while the privilege input is high. The handler then returns to the faulting access, which is issued again with the same address and now hits. Every entry carries an address-space tag, so translations from several processes can be held at once and a context switch does not require a flush. A full flush is still available and invalidates every entry in one cycle.

A refill is placed in one of three places, in this order. It overwrites an entry that already holds the same page and address space. Otherwise it goes to the lowest-numbered empty entry. Otherwise it replaces the least recently used entry.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, the physical address is {frame number, offset}, where the offset is the low 4 bits of the virtual address. All 16 offsets within a page translate through the same entry.
- R2: Results are registered. The hit, miss and physical address outputs reflect the lookup made in the previous cycle. In a cycle after one with the lookup-valid input low, both hit and miss are low.
- R3: If no entry matches a lookup, the next cycle shows miss high, hit low and a physical address of zero.
- R4: A write with the privilege input low changes no entry and no replacement order. A translation offered that way never hits, and the resident entries all still hit.
- R5: An entry hits only when three conditions hold together: its valid bit is set, its stored page number equals the looked-up page, and its stored address-space tag equals the current one.
- R6: A flush clears every valid bit in one cycle, so every following lookup misses. A flush in the same cycle as a write wins, and the write is dropped.
- R7: A refill that matches no resident entry goes to the lowest-numbered invalid entry, if any entry is invalid.
- R8: When every entry is valid, a refill evicts the least recently used entry. Each hit makes its entry the most recent, and so does each accepted refill. In a cycle with both a hit and a refill, only the refill updates the order.
- R9: A refill whose page number and address-space tag match a valid entry overwrites that entry in place. No other entry is displaced.
- R10: A lookup that missed, reissued unchanged after the matching refill, hits with the refilled frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 16 | Virtual address to translate |
| cur_asid | input | 4 | Address space of the running process |
| lk_hit | output | 1 | Registered: previous lookup hit |
| lk_miss | output | 1 | Registered: previous lookup missed (trap) |
| lk_paddr | output | 16 | Registered physical address, zero unless hit |
| priv | input | 1 | Privileged mode; enables the write port |
| wr_en | input | 1 | Refill request |
| wr_vpn | input | 12 | Page number to install |
| wr_asid | input | 4 | Address-space tag to install |
| wr_pfn | input | 12 | Frame number to install |
| flush | input | 1 | Invalidate all entries |

## Verification
Some properties are checked by assertions on every cycle. Hit and miss are never high together, and a result appears exactly when a lookup was made the cycle before. A miss carries a zero address, and a hit carries the offset of its lookup. A flush empties the valid bits. An unprivileged write leaves them untouched.

Other behaviour depends on the history of accesses and is covered only by the bench. That includes address-space matching, the choice of victim by emptiness and then by age, in-place overwrite, and the retry after a trap. The bench compares every lookup against a model that keeps a last-use timestamp per slot. It runs directed scenarios and then a long pseudo-random mix over a small set of pages and address spaces.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 12,
  parameter int ASID_W  = 4,
  parameter int PFN_W   = 12,
  parameter int OFF_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VPN_W+OFF_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0]        cur_asid,
  output logic                     lk_hit,
  output logic                     lk_miss,
  output logic [PFN_W+OFF_W-1:0]   lk_paddr,
  input  logic                     priv,
  input  logic                     wr_en,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [ASID_W-1:0]        wr_asid,
  input  logic [PFN_W-1:0]         wr_pfn,
  input  logic                     flush
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VA_W  = VPN_W + OFF_W;

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [IDX_W-1:0]   age_q  [ENTRIES];

  logic [ENTRIES-1:0] hit_vec, dup_vec;
  logic [PFN_W-1:0]   hit_pfn;
  logic [IDX_W-1:0]   hit_idx, victim, touch_idx;
  logic               found;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  wire             any_hit = lk_valid & (|hit_vec);
  wire             wr_ok   = wr_en & priv & ~flush;
  wire             touch   = wr_ok | any_hit;

  always_comb begin
    hit_pfn = '0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = valid[i] && vpn_q[i] == lk_vpn && asid_q[i] == cur_asid;
      dup_vec[i] = valid[i] && vpn_q[i] == wr_vpn && asid_q[i] == wr_asid;
      if (hit_vec[i]) begin
        hit_pfn = hit_pfn | pfn_q[i];
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && dup_vec[i]) begin victim = IDX_W'(i); found = 1'b1; end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !valid[i]) begin victim = IDX_W'(i); found = 1'b1; end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && age_q[i] == IDX_W'(ENTRIES - 1)) begin victim = IDX_W'(i); found = 1'b1; end
  end

  assign touch_idx = wr_ok ? victim : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= '0;
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_paddr <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      if (flush)      valid <= '0;
      else if (wr_ok) valid[victim] <= 1'b1;
      if (touch)
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      lk_hit   <= any_hit;
      lk_miss  <= lk_valid & ~(|hit_vec);
      lk_paddr <= any_hit ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      vpn_q[victim]  <= wr_vpn;
      asid_q[victim] <= wr_asid;
      pfn_q[victim]  <= wr_pfn;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 16,
  parameter int PA_W    = 16,
  parameter int OFF_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [PA_W-1:0]    lk_paddr,
  input logic               priv,
  input logic               wr_en,
  input logic               flush,
  input logic [ENTRIES-1:0] valid
);
  assert_hit_miss_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  assert_result_after_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (lk_hit || lk_miss));

  assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && !lk_miss));

  assert_miss_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> lk_paddr == '0);

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (lk_hit |-> lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid == '0);

  assert_unpriv_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv && !flush) |=> $stable(valid));
endmodule

bind asid_tlb asid_tlb_chk #(
  .ENTRIES(ENTRIES), .VA_W(VPN_W + OFF_W), .PA_W(PFN_W + OFF_W), .OFF_W(OFF_W)
) i_asid_tlb_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
  .priv(priv), .wr_en(wr_en), .flush(flush), .valid(valid)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_vaddr = '0;
  logic [3:0]  cur_asid = '0;
  logic        lk_hit, lk_miss;
  logic [15:0] lk_paddr;
  logic        priv = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_vpn = '0;
  logic [3:0]  wr_asid = '0;
  logic [11:0] wr_pfn = '0;
  logic        flush = 1'b0;

  int checks = 0;
  int errors = 0;

  bit        m_v    [N];
  bit [11:0] m_vpn  [N];
  bit [3:0]  m_asid [N];
  bit [11:0] m_pfn  [N];
  int        m_used [N];
  int        now = 0;
  int        seed = 32'h1234_5678;

  always #4 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .cur_asid(cur_asid), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .priv(priv), .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_pfn(wr_pfn), .flush(flush)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int model_find(input bit [11:0] vpn, input bit [3:0] asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  function automatic int model_victim(input bit [11:0] vpn, input bit [3:0] asid);
    int best;
    best = model_find(vpn, asid);
    if (best >= 0) return best;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    best = 0;
    for (int i = 1; i < N; i++) if (m_used[i] < m_used[best]) best = i;
    return best;
  endfunction

  task automatic lookup(input bit [15:0] va, input bit [3:0] asid, input string req);
    int k;
    bit [15:0] exp_pa;
    k = model_find(va[15:4], asid);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; cur_asid = asid;
    @(negedge clk);
    lk_valid = 1'b0;
    exp_pa = (k >= 0) ? {m_pfn[k], va[3:0]} : 16'h0;
    check(req, lk_hit == (k >= 0) && lk_miss == (k < 0) && lk_paddr == exp_pa,
          "lookup {hit,miss,paddr}", {14'd0, lk_hit, lk_miss, lk_paddr},
          {14'd0, k >= 0, k < 0, exp_pa});
    if (k >= 0) m_used[k] = ++now;
  endtask

  task automatic refill(input bit [11:0] vpn, input bit [3:0] asid, input bit [11:0] pfn,
                        input bit p, input bit fl);
    int k;
    @(negedge clk);
    wr_en = 1'b1; priv = p; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn; flush = fl;
    @(negedge clk);
    wr_en = 1'b0; priv = 1'b0; flush = 1'b0;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else if (p) begin
      k = model_victim(vpn, asid);
      m_v[k] = 1'b1; m_vpn[k] = vpn; m_asid[k] = asid; m_pfn[k] = pfn; m_used[k] = ++now;
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  function automatic int rnd(input int mod);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32'h7fff) % mod;
  endfunction

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_used[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", lk_hit == 0 && lk_miss == 0 && lk_paddr == 0, "reset outputs",
          {14'd0, lk_hit, lk_miss, lk_paddr}, 32'h0);
    lookup(16'h0123, 4'd1, "R3 empty");

    for (int i = 0; i < N; i++) refill(12'h100 + 12'(i), 4'd1, 12'hA00 + 12'(i * 3), 1'b1, 1'b0);
    for (int i = 0; i < N; i++)
      for (int o = 0; o < 16; o++) lookup({12'h100 + 12'(i), 4'(o)}, 4'd1, "R1 offsets");
    lookup(16'h1005, 4'd2, "R5 asid mismatch");
    lookup(16'h1F05, 4'd1, "R5 vpn mismatch");

    refill(12'h777, 4'd1, 12'h555, 1'b0, 1'b0);
    lookup(16'h7770, 4'd1, "R4 unpriv refill absent");
    for (int i = 0; i < N; i++) lookup({12'h100 + 12'(i), 4'h9}, 4'd1, "R4 residents kept");

    lookup(16'h1033, 4'd1, "R8 touch");
    lookup(16'h1001, 4'd1, "R8 touch");
    refill(12'h200, 4'd1, 12'hBEE, 1'b1, 1'b0);
    for (int i = 0; i < N; i++) lookup({12'h100 + 12'(i), 4'h2}, 4'd1, "R8 lru victim");
    lookup(16'h2004, 4'd1, "R8 new entry");

    refill(12'h200, 4'd1, 12'hC0D, 1'b1, 1'b0);
    lookup(16'h2007, 4'd1, "R9 overwrite in place");
    for (int i = 0; i < N; i++) lookup({12'h100 + 12'(i), 4'h6}, 4'd1, "R9 nothing displaced");

    do_flush();
    for (int i = 0; i < N; i++) lookup({12'h100 + 12'(i), 4'h0}, 4'd1, "R6 flushed");
    lookup(16'h200F, 4'd1, "R6 flushed");

    lookup(16'h3458, 4'd3, "R10 first miss");
    refill(12'h345, 4'd3, 12'h9AB, 1'b1, 1'b0);
    lookup(16'h3458, 4'd3, "R10 retry hits");
    refill(12'h346, 4'd3, 12'h111, 1'b1, 1'b0);
    refill(12'h345, 4'd2, 12'h222, 1'b1, 1'b0);
    lookup(16'h3451, 4'd2, "R7 invalid slot used");
    lookup(16'h3452, 4'd3, "R7 invalid slot used");
    lookup(16'h3463, 4'd3, "R7 invalid slot used");

    refill(12'h400, 4'd3, 12'h444, 1'b1, 1'b1);
    lookup(16'h4000, 4'd3, "R6 flush beats write");
    lookup(16'h3458, 4'd3, "R6 flush beats write");

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = rnd(64);
      if (op == 0) do_flush();
      else if (op < 20) refill(12'(rnd(12)), 4'(rnd(3)), 12'(rnd(4096)), rnd(8) != 0, 1'b0);
      else lookup({12'(rnd(12)), 4'(rnd(16))}, 4'(rnd(3)), "R8 R5 random mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule